// File: doc/BRIEF.md
# Branch Delay Slot and Exception Sequencer

This block generates the fetch address of a 32-bit core that has one architectural branch delay slot. On every step it takes one instruction's control-flow class and the data that instruction needs. That data is the branch condition, the 16-bit word offset, the 26-bit jump field, the register target, a trap request with its 5-bit code, and a request to enter user mode. From these it works out the address of the instruction after the one already fetched.

It tracks two things about the instruction currently being issued. The first is whether that instruction sits in a delay slot. The second is whether it is annulled, which happens either because it belongs to a branch-likely that was not taken or because it follows an excepting instruction.

On a trap the block does four things:
- It captures the return address, moved back one word when the victim sits in a delay slot.
- It records the code and the delay-slot marker in a cause word.
- It clears user mode.
- It raises a one-cycle request telling the register file to undo the victim's destination write.

Fetch then resumes at the trap vector. The register file, ALU and memory sit outside the block and consume `fetch_pc_o`, `annul_o` and `restore_o`.

Top module: `seq_top`

## Requirements
- R1: While `rst` is high, or after it is released and before any step, `fetch_pc_o` is 0x00000000, `fetch_pc_o` then steps to 0x00000004, and `dslot_o`, `annul_o`, `restore_o`, `user_o`, `epc_o` and `cause_o` are all zero.
- R2: The class encoding is 0 sequential, 1 branch, 2 branch-likely, 3 jump-immediate and 4 jump-register, and codes 5 to 7 act as sequential. For a sequential instruction that is not annulled, one step moves `fetch_pc_o` to the previously computed next address, and the address after that becomes 4 higher.
- R3: For a taken branch or branch-likely (`cond_i`=1), the address after the delay slot is the delay-slot address plus the sign-extended `imm_i` shifted left by 2, with the low two bits cleared. An untaken branch continues sequentially.
- R4: A jump-immediate targets the upper 4 bits of the jump's own address, followed by `jfield_i`, followed by two zero bits. A jump-register targets `jreg_i` with bits 1:0 cleared.
- R5: After any taken branch, taken branch-likely, jump-immediate or jump-register, the next issued instruction shows `dslot_o`=1. After any other executed instruction, `dslot_o` is 0.
- R6: An untaken branch-likely makes its delay-slot instruction issue with `annul_o`=1. A taken branch-likely leaves `annul_o`=0.
- R7: A step on an instruction issued with `annul_o`=1 ignores `cls_i`, `trap_i` and `uset_i`. It leaves `epc_o`, `cause_o` and `user_o` unchanged, clears `dslot_o` and `annul_o`, and continues sequentially.
- R8: A trap on an executed instruction loads `cause_o` with the delay-slot marker in bit 31, `code_i` in bits 4:0 and zeros elsewhere, where code 8 is a system call and code 9 a breakpoint. It also loads `epc_o` with the victim's address, minus 4 when the victim had `dslot_o`=1.
- R9: After a trap, the already-fetched next instruction issues with `annul_o`=1 and `dslot_o`=0, and the one after that is fetched from 0x0000003C. A control-flow request on the trapping step is ignored.
- R10: `restore_o` is high for exactly the cycle after a trap is taken, and a trap also clears `user_o`.
- R11: `uset_i` on an executed, non-trapping instruction sets `user_o` on the next cycle.
- R12: With `step_i` low, all state and outputs hold, and `restore_o` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Consume the instruction at `fetch_pc_o` this cycle |
| cls_i | input | 3 | Control-flow class of that instruction |
| cond_i | input | 1 | Branch condition result |
| imm_i | input | 16 | Branch word offset |
| jfield_i | input | 26 | Jump target field |
| jreg_i | input | 32 | Register jump target |
| trap_i | input | 1 | Trap request from this instruction |
| code_i | input | 5 | Trap cause code |
| uset_i | input | 1 | Request to enter user mode |
| fetch_pc_o | output | 32 | Address of the instruction being issued |
| dslot_o | output | 1 | Issued instruction sits in a delay slot |
| annul_o | output | 1 | Issued instruction must not write anything |
| restore_o | output | 1 | Undo the previous instruction's destination write |
| epc_o | output | 32 | Trap return address |
| cause_o | output | 32 | Trap cause word |
| user_o | output | 1 | User mode bit |

## Verification
The embedded assertions check the following on every cycle:
- The fetch address stays word aligned.
- An annulled instruction clears the annul and delay-slot flags.
- A trap is followed by annul and restore.
- The cause word's bit 31 and the return address follow the victim's delay-slot state.
- A trap clears user mode.
- An untaken likely branch annuls its slot.

Only the bench scenarios can show the full address arithmetic: sign-extended offsets, the top bits kept by a jump, and the full path of a trap through the vector fetch. The bench also covers traps raised inside delay slots and annulled instructions that carry trap or user requests.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    CF_SEQ  = 3'd0,
    CF_BR   = 3'd1,
    CF_BRL  = 3'd2,
    CF_JMP  = 3'd3,
    CF_JREG = 3'd4
  } cf_e;
endpackage

// File: rtl/seq_tgt_gen.sv
module seq_tgt_gen #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int JT_W  = 26
) (
  input  logic [2:0]      cls,
  input  logic            cond,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] pc_next,
  input  logic [IMM_W-1:0] imm,
  input  logic [JT_W-1:0] jf,
  input  logic [XLEN-1:0] jreg,
  output logic [XLEN-1:0] nxt,
  output logic            redir,
  output logic            annul_ds
);
  import seq_pkg::*;
  localparam int SX_W = XLEN - IMM_W - 2;
  localparam int HI_W = XLEN - JT_W - 2;

  logic [XLEN-1:0] seq_addr, br_addr, j_addr, jr_addr;

  assign seq_addr = pc_next + XLEN'(4);
  assign br_addr  = pc_next + {{SX_W{imm[IMM_W-1]}}, imm, 2'b00};
  assign j_addr   = {pc[XLEN-1 -: HI_W], jf, 2'b00};
  assign jr_addr  = {jreg[XLEN-1:2], 2'b00};

  always_comb begin
    nxt      = seq_addr;
    redir    = 1'b0;
    annul_ds = 1'b0;
    case (cls)
      CF_BR: begin
        redir = cond;
        nxt   = cond ? br_addr : seq_addr;
      end
      CF_BRL: begin
        redir    = cond;
        annul_ds = ~cond;
        nxt      = cond ? br_addr : seq_addr;
      end
      CF_JMP: begin
        redir = 1'b1;
        nxt   = j_addr;
      end
      CF_JREG: begin
        redir = 1'b1;
        nxt   = jr_addr;
      end
      default: ;
    endcase
    nxt[1:0] = 2'b00;
  end
endmodule

// File: rtl/seq_exc_regs.sv
module seq_exc_regs #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              in_ds,
  input  logic [XLEN-1:0]   pc,
  input  logic [CODE_W-1:0] code,
  input  logic              uset,
  output logic [XLEN-1:0]   epc,
  output logic [XLEN-1:0]   cause,
  output logic              user
);
  localparam int PAD_W = XLEN - CODE_W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      epc   <= '0;
      cause <= '0;
      user  <= 1'b0;
    end else if (take) begin
      epc   <= in_ds ? pc - XLEN'(4) : pc;
      cause <= {in_ds, {PAD_W{1'b0}}, code};
      user  <= 1'b0;
    end else if (uset) begin
      user  <= 1'b1;
    end
  end

  AST_CAUSE_DS: assert property (@(posedge clk) disable iff (rst)
    take |=> cause[XLEN-1] == $past(in_ds)); // R8
  AST_EPC_REWIND: assert property (@(posedge clk) disable iff (rst)
    (take && in_ds) |=> epc == $past(pc) - XLEN'(4)); // R8
  AST_USER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    take |=> !user); // R10
endmodule

// File: rtl/seq_top.sv
module seq_top #(
  parameter int          XLEN       = 32,
  parameter int          IMM_W      = 16,
  parameter int          JT_W       = 26,
  parameter int          CODE_W     = 5,
  parameter logic [31:0] RESET_ADDR = 32'h0000_0000,
  parameter logic [31:0] TRAP_VEC   = 32'h0000_003C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic [2:0]        cls_i,
  input  logic              cond_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [JT_W-1:0]   jfield_i,
  input  logic [XLEN-1:0]   jreg_i,
  input  logic              trap_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              uset_i,
  output logic [XLEN-1:0]   fetch_pc_o,
  output logic              dslot_o,
  output logic              annul_o,
  output logic              restore_o,
  output logic [XLEN-1:0]   epc_o,
  output logic [XLEN-1:0]   cause_o,
  output logic              user_o
);
  import seq_pkg::*;
  localparam logic [XLEN-1:0] RST_PC  = XLEN'(RESET_ADDR);
  localparam logic [XLEN-1:0] VEC_PC  = XLEN'(TRAP_VEC);
  localparam logic [XLEN-1:0] WORD    = XLEN'(4);

  logic [XLEN-1:0] pc_q, npc_q, nxt;
  logic            ds_q, sk_q, rs_q, redir, annul_ds;
  logic            exec, take, uset_take;

  assign exec      = step_i && !sk_q;
  assign take      = exec && trap_i;
  assign uset_take = exec && !trap_i && uset_i;

  seq_tgt_gen #(.XLEN(XLEN), .IMM_W(IMM_W), .JT_W(JT_W)) u_tgt (
    .cls(cls_i), .cond(cond_i), .pc(pc_q), .pc_next(npc_q),
    .imm(imm_i), .jf(jfield_i), .jreg(jreg_i),
    .nxt(nxt), .redir(redir), .annul_ds(annul_ds)
  );

  seq_exc_regs #(.XLEN(XLEN), .CODE_W(CODE_W)) u_exc (
    .clk(clk), .rst(rst), .take(take), .in_ds(ds_q), .pc(pc_q),
    .code(code_i), .uset(uset_take),
    .epc(epc_o), .cause(cause_o), .user(user_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= RST_PC;
      npc_q <= RST_PC + WORD;
      ds_q  <= 1'b0;
      sk_q  <= 1'b0;
      rs_q  <= 1'b0;
    end else begin
      rs_q <= take;
      if (step_i) begin
        pc_q <= npc_q;
        if (sk_q) begin
          npc_q <= npc_q + WORD;
          sk_q  <= 1'b0;
          ds_q  <= 1'b0;
        end else if (trap_i) begin
          npc_q <= VEC_PC;
          sk_q  <= 1'b1;
          ds_q  <= 1'b0;
        end else begin
          npc_q <= nxt;
          sk_q  <= annul_ds;
          ds_q  <= redir;
        end
      end
    end
  end

  assign fetch_pc_o = pc_q;
  assign dslot_o    = ds_q;
  assign annul_o    = sk_q;
  assign restore_o  = rs_q;

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    fetch_pc_o[1:0] == 2'b00); // R3
  AST_SKIP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (step_i && annul_o) |=> (!annul_o && !dslot_o && !restore_o)); // R7
  AST_TRAP_FLOW: assert property (@(posedge clk) disable iff (rst)
    (step_i && !annul_o && trap_i) |=> (annul_o && restore_o && !dslot_o)); // R9
  AST_LIKELY_ANNUL: assert property (@(posedge clk) disable iff (rst)
    (step_i && !annul_o && !trap_i && cls_i == CF_BRL && !cond_i) |=> annul_o); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> ($stable(fetch_pc_o) && $stable(annul_o) && !restore_o)); // R12
endmodule

// File: tb/sim_seq_top.sv
module sim_seq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_i = 1'b0;
  logic [2:0]  cls_i = '0;
  logic        cond_i = 1'b0;
  logic [15:0] imm_i = '0;
  logic [25:0] jfield_i = '0;
  logic [31:0] jreg_i = '0;
  logic        trap_i = 1'b0;
  logic [4:0]  code_i = '0;
  logic        uset_i = 1'b0;
  logic [31:0] fetch_pc_o, epc_o, cause_o;
  logic        dslot_o, annul_o, restore_o, user_o;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model state
  logic [31:0] m_pc, m_npc, m_epc, m_cause;
  logic        m_ds, m_sk, m_rs, m_usr;

  always #2.5 clk = ~clk;

  seq_top u0 (
    .clk(clk), .rst(rst), .step_i(step_i), .cls_i(cls_i), .cond_i(cond_i),
    .imm_i(imm_i), .jfield_i(jfield_i), .jreg_i(jreg_i), .trap_i(trap_i),
    .code_i(code_i), .uset_i(uset_i), .fetch_pc_o(fetch_pc_o),
    .dslot_o(dslot_o), .annul_o(annul_o), .restore_o(restore_o),
    .epc_o(epc_o), .cause_o(cause_o), .user_o(user_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_addr(input logic [2:0] c, input logic t,
      input logic [15:0] im, input logic [25:0] jf, input logic [31:0] jr);
    logic [31:0] r;
    r = m_npc + 32'd4;
    if ((c == 3'd1 || c == 3'd2) && t) r = m_npc + {{14{im[15]}}, im, 2'b00};
    if (c == 3'd3) r = {m_pc[31:28], jf, 2'b00};
    if (c == 3'd4) r = jr;
    return {r[31:2], 2'b00};
  endfunction

  task automatic model_reset();
    m_pc = 32'h0; m_npc = 32'h4; m_ds = 0; m_sk = 0; m_rs = 0;
    m_usr = 0; m_epc = 0; m_cause = 0;
  endtask

  task automatic model_step();
    logic tk;
    tk   = step_i && !m_sk && trap_i;
    m_rs = tk;
    if (!step_i) return;
    if (m_sk) begin
      m_pc = m_npc; m_npc = m_npc + 4; m_sk = 0; m_ds = 0;
    end else if (trap_i) begin
      m_epc   = m_ds ? m_pc - 4 : m_pc;
      m_cause = {m_ds, 26'd0, code_i};
      m_usr   = 0;
      m_pc = m_npc; m_npc = 32'h3C; m_sk = 1; m_ds = 0;
    end else begin
      logic [31:0] n;
      logic red;
      n   = next_addr(cls_i, cond_i, imm_i, jfield_i, jreg_i);
      red = ((cls_i == 3'd1 || cls_i == 3'd2) && cond_i) || cls_i == 3'd3 || cls_i == 3'd4;
      if (uset_i) m_usr = 1;
      m_sk = (cls_i == 3'd2) && !cond_i;
      m_ds = red;
      m_pc = m_npc; m_npc = n;
    end
  endtask

  task automatic compare_all();
    chk("R2/R3/R4 fetch_pc", fetch_pc_o, m_pc);
    chk("R5 dslot", {31'd0, dslot_o}, {31'd0, m_ds});
    chk("R6/R7 annul", {31'd0, annul_o}, {31'd0, m_sk});
    chk("R10 restore", {31'd0, restore_o}, {31'd0, m_rs});
    chk("R8 epc", epc_o, m_epc);
    chk("R8 cause", cause_o, m_cause);
    chk("R11 user", {31'd0, user_o}, {31'd0, m_usr});
  endtask

  task automatic drive(input logic st, input logic [2:0] c, input logic t,
      input logic [15:0] im, input logic [25:0] jf, input logic [31:0] jr,
      input logic tr, input logic [4:0] cd, input logic us);
    step_i = st; cls_i = c; cond_i = t; imm_i = im; jfield_i = jf;
    jreg_i = jr; trap_i = tr; code_i = cd; uset_i = us;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 reset pc", fetch_pc_o, 32'h0);
    compare_all();
    drive(1, 3'd0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 first step pc", fetch_pc_o, 32'h4);
    // R3 taken branch offset 0x10 words from slot 8
    drive(1, 3'd1, 1, 16'h0010, 0, 0, 0, 0, 0);
    chk("R5 slot flagged", {31'd0, dslot_o}, 32'd1);
    drive(1, 3'd0, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 branch target", fetch_pc_o, 32'h48);
    // R8 breakpoint outside slot
    drive(1, 3'd0, 0, 0, 0, 0, 1, 5'd9, 0);
    chk("R8 cause break", cause_o, 32'h9);
    chk("R8 epc plain", epc_o, 32'h48);
    chk("R9 annulled next", {31'd0, annul_o}, 32'd1);
    drive(1, 3'd3, 0, 0, 26'h123, 0, 1, 5'd3, 1); // R7 ignored on annulled slot
    chk("R9 vector fetch", fetch_pc_o, 32'h3C);
    chk("R7 cause untouched", cause_o, 32'h9);
    // R6 untaken likely with negative offset
    drive(1, 3'd2, 0, 16'hFFFE, 0, 0, 0, 0, 0);
    chk("R6 untaken likely annuls", {31'd0, annul_o}, 32'd1);
    drive(1, 3'd0, 0, 0, 0, 0, 0, 0, 0);
    // R4 jump then trap in slot -> epc rewind, syscall code 8
    drive(1, 3'd3, 0, 0, 26'h0000_100, 0, 0, 0, 1);
    chk("R11 user set", {31'd0, user_o}, 32'd1);
    drive(1, 3'd0, 0, 0, 0, 0, 1, 5'd8, 0);
    chk("R8 slot cause", cause_o, 32'h8000_0008);
    chk("R10 user cleared", {31'd0, user_o}, 32'd0);
    chk("R10 restore pulse", {31'd0, restore_o}, 32'd1);
    // R12 hold
    drive(0, 3'd4, 0, 0, 0, 32'hFFFF_FFFF, 1, 0, 1);
    chk("R12 hold restore low", {31'd0, restore_o}, 32'd0);
    // R4 register jump with misaligned low bits
    drive(1, 3'd0, 0, 0, 0, 0, 0, 0, 0);
    drive(1, 3'd4, 0, 0, 0, 32'h0000_1237, 0, 0, 0);
    drive(1, 3'd0, 0, 0, 0, 0, 0, 0, 0);
    chk("R4 jreg aligned", fetch_pc_o, 32'h0000_1234);
    // random traffic checked against model
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      drive((r[3:0] != 0), 3'($urandom_range(0, 6)), r[4], 16'($urandom),
            26'($urandom), $urandom, (r[7:5] == 0), 5'($urandom), (r[10:8] == 0));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule